// File: doc/BRIEF.md
# Execute-Stage ALU with Condition Flags

This block is the arithmetic core of the execute stage for a small 64-bit teaching processor. It combines two operands under a 4-bit function code and returns the result in the same cycle. It supports addition, subtraction, bitwise AND and bitwise XOR. The same adder also forms effective addresses and moves the stack pointer by 8. For those uses the surrounding pipeline raises the class select, and the block then always adds.

The block holds three condition flags: zero, sign and signed overflow. It loads them on a clock edge, and only when an integer operation with a defined function code is issued with its flag-write enable raised. While the class select is high, the function code instead chooses one of seven predicates over the stored flags. The same predicate table serves branches and conditional moves. The predicate drives a single condition-true output. Data passes straight through with no storage, so the block has no valid/ready handshake and never applies back-pressure. The operands are consumed in the cycle they are presented.

Top module: `yexec_unit`

## Requirements
- R1: With class select 0 and function code 0, the result is operand A plus operand B, modulo 2^64.
- R2: With class select 0 and function code 1, the result is operand B minus operand A, modulo 2^64.
- R3: With class select 0, function code 2 gives A AND B and function code 3 gives A XOR B.
- R4: With class select 0 and a function code from 4 to 15, the result is zero and the flags keep their value even when flag-write is high.
- R5: With class select 1, the result is A plus B for every function code, and the flags are never written.
- R6: The flags output is {ZF, SF, OF}, with ZF in bit 2 and OF in bit 0. It changes only on a rising clock edge where flag-write is 1, class select is 0 and the function code is 0 to 3. Otherwise it holds.
- R7: On a flag write, ZF is 1 exactly when the 64-bit result is zero, and SF takes result bit 63.
- R8: On a flag write, OF is signed overflow for add (code 0) and subtract (code 1), and 0 for AND and XOR.
- R9: An active-low reset sets the flags to ZF=1, SF=0, OF=0 (value 3'b100) at once, without waiting for a clock edge.
- R10: With class select 1, condition-true is computed from the stored flags, with lt = SF^OF. Code 0 is always, 1 is lt|ZF, 2 is lt, 3 is ZF, 4 is ~ZF, 5 is ~lt, and 6 is ~lt&~ZF.
- R11: Condition-true is 0 for codes 7 to 15 under class select 1, and 0 whenever class select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags load on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| opnd_a_i | input | 64 | Operand A (the subtrahend for subtract) |
| opnd_b_i | input | 64 | Operand B |
| fn_i | input | 4 | Operation code or condition code, depending on the class select |
| cond_cls_i | input | 1 | 0: integer operation; 1: address add and condition evaluation |
| set_flags_i | input | 1 | Flag-write enable |
| result_o | output | 64 | Combinational result |
| flags_o | output | 3 | Stored flags {ZF, SF, OF} |
| cond_true_o | output | 1 | Selected predicate over the stored flags |

## Verification
The checker assumes that every input carries a known value at each rising edge while reset is released. A flag write is decided only from the levels present at that edge. The bench changes inputs only on falling edges, one vector per cycle. It keeps inputs defined from time zero, including throughout reset. Every function code from 0 to 15 is swept under the condition class, over flag states built from ordinary subtracts and adds. The bench needs no forced internal values, because every reachable flag pattern comes through the normal operation path.

// File: rtl/yexec_pkg.sv
package yexec_pkg;
  localparam int FN_W = 4;

  typedef enum logic [FN_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_XOR = 4'd3
  } alu_op_e;

  typedef enum logic [FN_W-1:0] {
    CC_ALWAYS = 4'd0,
    CC_LE     = 4'd1,
    CC_LT     = 4'd2,
    CC_EQ     = 4'd3,
    CC_NE     = 4'd4,
    CC_GE     = 4'd5,
    CC_GT     = 4'd6
  } cond_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } ccodes_t;

  localparam ccodes_t CC_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

  // Predicate over stored flags for one condition code
  function automatic logic cond_pred(input ccodes_t cc, input logic [FN_W-1:0] code);
    logic lt;
    lt = cc.sf ^ cc.of;
    case (code)
      CC_ALWAYS: cond_pred = 1'b1;
      CC_LE:     cond_pred = lt | cc.zf;
      CC_LT:     cond_pred = lt;
      CC_EQ:     cond_pred = cc.zf;
      CC_NE:     cond_pred = ~cc.zf;
      CC_GE:     cond_pred = ~lt;
      CC_GT:     cond_pred = ~lt & ~cc.zf;
      default:   cond_pred = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/yexec_alu.sv
module yexec_alu
  import yexec_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [FN_W-1:0] fn_i,
  input  logic            force_add_i,
  output logic [W-1:0]    res_o,
  output ccodes_t         nxt_cc_o,
  output logic            op_ok_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] sum_v, dif_v;
  logic         add_ovf, sub_ovf, ovf;

  assign sum_v   = a_i + b_i;
  assign dif_v   = b_i - a_i;
  assign add_ovf = (a_i[MSB] == b_i[MSB]) && (sum_v[MSB] != a_i[MSB]);
  assign sub_ovf = (b_i[MSB] != a_i[MSB]) && (dif_v[MSB] != b_i[MSB]);

  always_comb begin
    res_o   = '0;
    ovf     = 1'b0;
    op_ok_o = 1'b1;
    if (force_add_i) begin
      res_o = sum_v;
      ovf   = add_ovf;
    end else begin
      case (fn_i)
        OP_ADD: begin res_o = sum_v; ovf = add_ovf; end
        OP_SUB: begin res_o = dif_v; ovf = sub_ovf; end
        OP_AND: res_o = a_i & b_i;
        OP_XOR: res_o = a_i ^ b_i;
        default: begin
          res_o   = '0;
          op_ok_o = 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    nxt_cc_o.zf = (res_o == '0);
    nxt_cc_o.sf = res_o[MSB];
    nxt_cc_o.of = ovf;
  end
endmodule

// File: rtl/yexec_ccreg.sv
module yexec_ccreg
  import yexec_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    we_i,
  input  ccodes_t d_i,
  output ccodes_t q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= CC_RESET;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/yexec_cond.sv
module yexec_cond
  import yexec_pkg::*;
(
  input  ccodes_t         cc_i,
  input  logic [FN_W-1:0] code_i,
  input  logic            en_i,
  output logic            take_o
);
  localparam int NCODES = 1 << FN_W;

  logic [NCODES-1:0] pred_tbl;

  for (genvar g = 0; g < NCODES; g++) begin : g_pred
    assign pred_tbl[g] = cond_pred(cc_i, FN_W'(g));
  end

  assign take_o = en_i & pred_tbl[code_i];
endmodule

// File: rtl/yexec_unit.sv
module yexec_unit
  import yexec_pkg::*;
#(
  parameter int W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    opnd_a_i,
  input  logic [W-1:0]    opnd_b_i,
  input  logic [FN_W-1:0] fn_i,
  input  logic            cond_cls_i,
  input  logic            set_flags_i,
  output logic [W-1:0]    result_o,
  output logic [2:0]      flags_o,
  output logic            cond_true_o
);
  ccodes_t nxt_cc, cur_cc;
  logic    op_ok, cc_we;

  yexec_alu #(.W(W)) u_alu (
    .a_i        (opnd_a_i),
    .b_i        (opnd_b_i),
    .fn_i       (fn_i),
    .force_add_i(cond_cls_i),
    .res_o      (result_o),
    .nxt_cc_o   (nxt_cc),
    .op_ok_o    (op_ok)
  );

  assign cc_we = set_flags_i & ~cond_cls_i & op_ok;

  yexec_ccreg u_ccreg (
    .clk  (clk),
    .rst_n(rst_n),
    .we_i (cc_we),
    .d_i  (nxt_cc),
    .q_o  (cur_cc)
  );

  yexec_cond u_cond (
    .cc_i  (cur_cc),
    .code_i(fn_i),
    .en_i  (cond_cls_i),
    .take_o(cond_true_o)
  );

  assign flags_o = cur_cc;
endmodule

// File: rtl/yexec_unit_chk.sv
module yexec_unit_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] opnd_a_i,
  input logic [W-1:0] opnd_b_i,
  input logic [3:0]   fn_i,
  input logic         cond_cls_i,
  input logic         set_flags_i,
  input logic [W-1:0] result_o,
  input logic [2:0]   flags_o,
  input logic         cond_true_o
);
  logic no_write;
  assign no_write = !set_flags_i || cond_cls_i || (fn_i > 4'd3);

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    no_write |=> $stable(flags_o)); // R6

  AST_RESET_FLAGS: assert property (@(posedge clk)
    !rst_n |=> (flags_o == 3'b100)); // R9

  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!cond_cls_i && fn_i > 4'd3) |-> (result_o == '0)); // R4

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!no_write && result_o == '0) |=> flags_o[2]); // R7

  AST_LOGIC_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags_i && !cond_cls_i && (fn_i == 4'd2 || fn_i == 4'd3)) |=> !flags_o[0]); // R8

  AST_COND_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cond_cls_i || fn_i > 4'd6) |-> !cond_true_o); // R11

  AST_EQ_TRACKS_ZF: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_cls_i && fn_i == 4'd3) |-> (cond_true_o == flags_o[2])); // R10

  AST_ADDR_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    cond_cls_i |-> (result_o == opnd_a_i + opnd_b_i)); // R5
endmodule

bind yexec_unit yexec_unit_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .opnd_a_i   (opnd_a_i),
  .opnd_b_i   (opnd_b_i),
  .fn_i       (fn_i),
  .cond_cls_i (cond_cls_i),
  .set_flags_i(set_flags_i),
  .result_o   (result_o),
  .flags_o    (flags_o),
  .cond_true_o(cond_true_o)
);

// File: tb/yexec_unit_bench.sv
module yexec_unit_bench;
  localparam int CLK_P = 10;
  localparam logic [63:0] MAXP = 64'h7fff_ffff_ffff_ffff;
  localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic [3:0]  fn = '0;
  logic        cls = 1'b0, setf = 1'b0;
  logic [63:0] result;
  logic [2:0]  flags;
  logic        cond_true;

  int vectors = 0;
  int miscompares = 0;

  typedef struct {
    logic [63:0] res;
    logic        cnd;
    logic [2:0]  flg;
    string       t_res;
    string       t_cnd;
    string       t_flg;
  } exp_t;

  exp_t        sb_q[$];
  logic [2:0]  mf = 3'b100;

  always #(CLK_P/2) clk = ~clk;

  yexec_unit u_yexec_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .opnd_a_i   (opnd_a),
    .opnd_b_i   (opnd_b),
    .fn_i       (fn),
    .cond_cls_i (cls),
    .set_flags_i(setf),
    .result_o   (result),
    .flags_o    (flags),
    .cond_true_o(cond_true)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // Driver: applies one vector on a falling edge and queues its expectation
  task automatic drive(input logic [63:0] a, input logic [63:0] b,
                       input logic [3:0] f, input logic c, input logic s);
    exp_t e;
    logic [63:0] r;
    logic lt, o;
    @(negedge clk);
    opnd_a = a; opnd_b = b; fn = f; cls = c; setf = s;
    if (c) begin r = a + b; e.t_res = "R5"; end
    else case (f)
      4'd0: begin r = a + b; e.t_res = "R1"; end
      4'd1: begin r = b - a; e.t_res = "R2"; end
      4'd2: begin r = a & b; e.t_res = "R3"; end
      4'd3: begin r = a ^ b; e.t_res = "R3"; end
      default: begin r = '0; e.t_res = "R4"; end
    endcase
    e.res = r;
    lt = mf[1] ^ mf[0];
    e.t_cnd = "R10";
    if (!c) begin e.cnd = 1'b0; e.t_cnd = "R11"; end
    else case (f)
      4'd0: e.cnd = 1'b1;
      4'd1: e.cnd = lt | mf[2];
      4'd2: e.cnd = lt;
      4'd3: e.cnd = mf[2];
      4'd4: e.cnd = ~mf[2];
      4'd5: e.cnd = ~lt;
      4'd6: e.cnd = ~lt & ~mf[2];
      default: begin e.cnd = 1'b0; e.t_cnd = "R11"; end
    endcase
    if (s && !c && f < 4'd4) begin
      if (f == 4'd0)      o = (a[63] == b[63]) && (r[63] != a[63]);
      else if (f == 4'd1) o = (b[63] != a[63]) && (r[63] != b[63]);
      else                o = 1'b0;
      mf = {(r == 64'd0), r[63], o};
      e.t_flg = "R7/R8";
    end else begin
      e.t_flg = (!c && f > 4'd3) ? "R4" : (c ? "R5" : "R6");
    end
    e.flg = mf;
    sb_q.push_back(e);
  endtask

  task automatic sweep_cond(input logic [63:0] a, input logic [63:0] b);
    for (int k = 0; k < 16; k++) drive(a, b, 4'(k), 1'b1, 1'b1);
  endtask

  // Monitor: compares each queued item against the outputs
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        vectors++;
        chk(e.t_res, result, e.res);
        chk(e.t_cnd, {63'd0, cond_true}, {63'd0, e.cnd});
        @(posedge clk);
        #1;
        chk(e.t_flg, {61'd0, flags}, {61'd0, e.flg});
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    chk("R9", {61'd0, flags}, 64'd4);            // R9 reset value
    rst_n = 1'b1;
    sweep_cond(64'd1, 64'd2);                     // R10 from reset flags (ZF)
    drive(64'd5, 64'd7, 4'd0, 1'b0, 1'b1);        // R1 plain add
    drive(MAXP, 64'd1, 4'd0, 1'b0, 1'b1);         // R1/R8 add overflow
    drive(64'd9, 64'd0 - 64'd9, 4'd0, 1'b0, 1'b1);// R7 add to zero
    drive(64'd3, 64'd10, 4'd1, 1'b0, 1'b1);       // R2 subtract
    drive(64'd1, MINN, 4'd1, 1'b0, 1'b1);         // R2/R8 subtract overflow
    drive(64'hf0f0, 64'hff00, 4'd2, 1'b0, 1'b1);  // R3 and
    drive(MINN, 64'h1234, 4'd3, 1'b0, 1'b1);      // R3 xor, SF set, OF clear
    drive(64'h55, 64'h55, 4'd3, 1'b0, 1'b1);      // R3/R7 xor to zero
    drive(64'd4, 64'd4, 4'd7, 1'b0, 1'b1);        // R4 undefined code
    drive(64'd1, 64'd2, 4'd15, 1'b0, 1'b1);       // R4 undefined code
    drive(64'd8, 64'hff0, 4'd1, 1'b1, 1'b1);      // R5 address add, no write
    drive(64'd3, 64'd4, 4'd1, 1'b0, 1'b0);        // R6 write disabled
    drive(64'd5, 64'd5, 4'd1, 1'b0, 1'b1);        // equal state
    sweep_cond(64'd0, 64'd8);
    drive(64'd9, 64'd3, 4'd1, 1'b0, 1'b1);        // less state
    sweep_cond(64'd16, 64'd24);
    drive(64'd3, 64'd9, 4'd1, 1'b0, 1'b1);        // greater state
    sweep_cond(64'd0, 64'd0);
    drive(64'd1, MINN, 4'd1, 1'b0, 1'b1);         // less through overflow
    sweep_cond(MAXP, 64'd1);
    drive(MAXP, MAXP, 4'd0, 1'b0, 1'b1);          // ge through overflow
    sweep_cond(64'd2, 64'd3);
    @(negedge clk);
    setf = 1'b0; cls = 1'b0; fn = 4'd0;
    while (sb_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    rst_n = 1'b0;                                 // R9 asynchronous reset
    #1;
    vectors++;
    chk("R9", {61'd0, flags}, 64'd4);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule